// File: doc/BRIEF.md
# Modem Status Change Tracker

This block watches four modem control lines coming from outside the chip: clear-to-send, data-set-ready, ring indicator and carrier detect. It presents one 8-bit status byte to the host register interface. The upper half of the byte shows the present level of each line. The lower half holds sticky flags that record a change on a line since the host last read the byte. Each raw line passes through a two-flop synchroniser before the block looks at it.

Three of the flags are set by a change in either direction. The ring flag is set only when the ring line goes from inactive to active. A read strobe from the host clears the flags at the end of the read cycle. The host sees the byte as it stood before the clear. A change that lands on the same clock edge as the clear still sets its flag. An interrupt request is raised while any flag is set and the interrupt enable input is high.

After a synchronous active-low reset the byte reads zero. The block then picks up the live line levels. Any line that is active during reset therefore raises its change flag (ring included), as if it had just been connected.

Top module: `modem_status_tracker`

## Requirements
- R1: Status bits 4, 5, 6 and 7 show the synchronised levels of clear-to-send, data-set-ready, ring indicator and carrier detect. A change on a raw line that is stable at clock edge n appears in the byte after edge n+2.
- R2: Bit 0 is set on the same edge where bit 4 changes, in either direction.
- R3: Bit 1 is set on the same edge where bit 5 changes, in either direction.
- R4: Bit 3 is set on the same edge where bit 7 changes, in either direction.
- R5: Bit 2 is set only on an edge where bit 6 goes from 0 to 1. A 1-to-0 change of bit 6 leaves bit 2 unchanged.
- R6: While reset is low, the status byte is 0x00 and the interrupt is low. After reset, a line held active raises its change flag as its level appears.
- R7: Bits 0 to 3 stay set until a cycle with the read strobe high. After that cycle they are cleared, unless R8 applies. While the strobe is high, the byte still shows the value from before the clear.
- R8: A change that falls on the edge that ends a read cycle leaves its flag set.
- R9: The interrupt output is high exactly when the enable input is high and at least one of bits 0 to 3 is set.
- R10: Holding the enable input low masks the interrupt but does not clear or stop the change flags.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cts_raw | input | 1 | Clear-to-send line, asynchronous |
| dsr_raw | input | 1 | Data-set-ready line, asynchronous |
| ri_raw | input | 1 | Ring indicator line, asynchronous |
| dcd_raw | input | 1 | Carrier detect line, asynchronous |
| rd_stb | input | 1 | Host read strobe for the status byte |
| irq_en | input | 1 | Modem-status interrupt enable |
| status | output | 8 | Levels in bits 7:4, change flags in bits 3:0 |
| irq | output | 1 | Modem-status interrupt request |

## Verification
Two events can land on one clock edge: the clear from a host read, and a freshly detected line change. The bench provokes this in two ways. In a directed sequence, the read strobe is timed to cover the third edge after a toggle of data-set-ready. In a long random phase, reads and line toggles are scattered freely. A flag that survives the read is judged correct only when the line level changed on that same edge. A behavioural model, built from a queue of past input samples, decides this every cycle and compares it with the status byte.

// File: rtl/msc_pkg.sv
// Package: shared constants for the modem status tracker.
// Assumes the line index order below is also the status bit order.
package msc_pkg;
    localparam int NUM_LINES   = 4;
    localparam int SYNC_STAGES = 2;
    localparam int STATUS_W    = 2 * NUM_LINES;
    // Line indices: the level sits at bit NUM_LINES+idx, the flag at bit idx
    localparam int LINE_CTS = 0;
    localparam int LINE_DSR = 1;
    localparam int LINE_RI  = 2;
    localparam int LINE_DCD = 3;
endpackage

// File: rtl/msc_sync.sv
// Module: msc_sync
// Multi-stage synchroniser for a vector of asynchronous lines.
// Assumes each line is a slow level signal, so each bit is synchronised on its own.
module msc_sync #(
    parameter int WIDTH  = 4,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d_async,
    output logic [WIDTH-1:0] q_sync
);
    logic [WIDTH-1:0] chain [STAGES];

    genvar s;
    generate
        for (s = 0; s < STAGES; s++) begin : g_stage
            // Purpose: shift the line vector one flop further along the chain
            always_ff @(posedge clk) begin
                if (!rst_n)
                    chain[s] <= '0;
                else if (s == 0)
                    chain[s] <= d_async;
                else
                    chain[s] <= chain[(s == 0) ? 0 : s-1];
            end
        end
    endgenerate

    assign q_sync = chain[STAGES-1];
endmodule

// File: rtl/msc_delta.sv
// Module: msc_delta
// Tracks one synchronised line: it holds the recorded level and a sticky change flag.
// RISE_ONLY=1 arms the flag only on an inactive-to-active step.
// Assumes clr comes from a host read. A change on the same edge as clr wins over it.
module msc_delta #(
    parameter bit RISE_ONLY = 1'b0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic lvl_now,
    input  logic clr,
    output logic lvl_q,
    output logic flag_q
);
    logic hit;

    generate
        if (RISE_ONLY) begin : g_rise
            assign hit = lvl_now & ~lvl_q;
        end else begin : g_any
            assign hit = lvl_now ^ lvl_q;
        end
    endgenerate

    // Purpose: record the level every clock and keep the flag until a read clears it
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lvl_q  <= 1'b0;
            flag_q <= 1'b0;
        end else begin
            lvl_q  <= lvl_now;
            flag_q <= (clr ? 1'b0 : flag_q) | hit;
        end
    end
endmodule

// File: rtl/modem_status_tracker.sv
// Module: modem_status_tracker (top)
// Synchronises the four modem lines and keeps the status byte: levels high, change flags low.
// It raises an interrupt when enabled and any flag is set.
// Assumes rd_stb is high for one cycle per host read of the byte.
module modem_status_tracker
    import msc_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       cts_raw,
    input  logic       dsr_raw,
    input  logic       ri_raw,
    input  logic       dcd_raw,
    input  logic       rd_stb,
    input  logic       irq_en,
    output logic [7:0] status,
    output logic       irq
);
    logic [NUM_LINES-1:0] raw_vec;
    logic [NUM_LINES-1:0] sync_vec;
    logic [NUM_LINES-1:0] lvl_vec;
    logic [NUM_LINES-1:0] flag_vec;

    assign raw_vec[LINE_CTS] = cts_raw;
    assign raw_vec[LINE_DSR] = dsr_raw;
    assign raw_vec[LINE_RI]  = ri_raw;
    assign raw_vec[LINE_DCD] = dcd_raw;

    msc_sync #(.WIDTH(NUM_LINES), .STAGES(SYNC_STAGES)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .d_async (raw_vec),
        .q_sync  (sync_vec)
    );

    genvar i;
    generate
        for (i = 0; i < NUM_LINES; i++) begin : g_line
            msc_delta #(.RISE_ONLY(i == LINE_RI)) u_delta (
                .clk    (clk),
                .rst_n  (rst_n),
                .lvl_now(sync_vec[i]),
                .clr    (rd_stb),
                .lvl_q  (lvl_vec[i]),
                .flag_q (flag_vec[i])
            );
        end
    endgenerate

    // Purpose: assemble the status byte and the gated interrupt request
    always_comb begin
        status = {lvl_vec, flag_vec};
        irq    = irq_en & (|flag_vec);
    end
endmodule

// File: rtl/modem_status_tracker_chk.sv
// Module: modem_status_tracker_chk
// Property checker for the modem status tracker. It watches only the top-level ports.
// It is attached to every instance of the top by the bind statement below.
module modem_status_tracker_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       rd_stb,
    input logic       irq_en,
    input logic [7:0] status,
    input logic       irq
);
    // R2: a CTS level change comes with its flag on the same edge
    a_r2_cts_flag: assert property (@(posedge clk) disable iff (!rst_n)
        (status[4] != $past(status[4])) |-> status[0]);
    // R3: a DSR level change comes with its flag
    a_r3_dsr_flag: assert property (@(posedge clk) disable iff (!rst_n)
        (status[5] != $past(status[5])) |-> status[1]);
    // R4: a DCD level change comes with its flag
    a_r4_dcd_flag: assert property (@(posedge clk) disable iff (!rst_n)
        (status[7] != $past(status[7])) |-> status[3]);
    // R5: a ring rise comes with the ring flag
    a_r5_ring_rise: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(status[6]) |-> status[2]);
    // R5: the ring flag never appears while the ring level drops
    a_r5_ring_fall: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(status[6]) && !$past(status[2])) |-> !status[2]);
    // R7: without a read, no set flag is lost
    a_r7_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_stb |=> ((status[3:0] & $past(status[3:0])) == $past(status[3:0])));
    // R9: the interrupt stays low while disabled
    a_r9_masked: assert property (@(posedge clk) disable iff (!rst_n)
        !irq_en |-> !irq);
    // R9: the interrupt is high when enabled with a pending flag
    a_r9_raise: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_en && (status[3:0] != 4'd0)) |-> irq);
endmodule

bind modem_status_tracker modem_status_tracker_chk u_chk (
    .clk    (clk),
    .rst_n  (rst_n),
    .rd_stb (rd_stb),
    .irq_en (irq_en),
    .status (status),
    .irq    (irq)
);

// File: tb/sim_modem_status_tracker.sv
module sim_modem_status_tracker;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cts = 0, dsr = 0, ri = 0, dcd = 0, rd = 0, en = 0;
    logic [7:0] status;
    logic irq;
    int total = 0;
    int bad = 0;
    bit finished = 0;

    always #2.5 clk = ~clk;

    modem_status_tracker u0 (
        .clk(clk), .rst_n(rst_n), .cts_raw(cts), .dsr_raw(dsr), .ri_raw(ri),
        .dcd_raw(dcd), .rd_stb(rd), .irq_en(en), .status(status), .irq(irq)
    );

    // Behavioural reference: a queue of past input vectors supplies the synchronised level
    logic [3:0] hist [$];
    logic [3:0] m_lvl = 4'd0;
    logic [3:0] m_flag = 4'd0;

    always @(posedge clk) begin
        if (!rst_n) begin
            hist = {4'd0, 4'd0};
            m_lvl = 4'd0;
            m_flag = 4'd0;
        end else begin
            logic [3:0] now, hit;
            hist.push_back({dcd, ri, dsr, cts});
            now = hist.pop_front();
            hit = now ^ m_lvl;
            hit[2] = now[2] & ~m_lvl[2];
            m_flag = (rd ? 4'd0 : m_flag) | hit;
            m_lvl = now;
        end
    end

    task automatic chk(string tag, logic [7:0] act, logic [7:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    // Cycle compare against the model, one check per requirement field
    always @(negedge clk) begin
        if (!finished) begin
            chk("R1 levels", {4'd0, status[7:4]}, {4'd0, m_lvl});
            chk("R2 cts flag", {7'd0, status[0]}, {7'd0, m_flag[0]});
            chk("R3 dsr flag", {7'd0, status[1]}, {7'd0, m_flag[1]});
            chk("R5 ring flag", {7'd0, status[2]}, {7'd0, m_flag[2]});
            chk("R4 dcd flag", {7'd0, status[3]}, {7'd0, m_flag[3]});
            chk("R9 irq", {7'd0, irq}, {7'd0, en && (m_flag != 4'd0)});
        end
    end

    task automatic tick(int n = 1);
        repeat (n) begin
            @(posedge clk);
            #1;
        end
    endtask

    task automatic peek();
        @(negedge clk);
    endtask

    initial begin
        #1000000;
        if (!finished) begin
            bad++;
            total++;
            $display("FAIL watchdog act=hung exp=done");
            finished = 1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        // R6: lines active during reset; the byte must stay zero
        cts = 1; ri = 1; en = 1;
        tick(4);
        peek();
        chk("R6 reset byte", status, 8'h00);
        chk("R6 reset irq", {7'd0, irq}, 8'h00);
        rst_n = 1;
        tick(5);
        peek();
        chk("R6 post-reset pickup", status, 8'h55);
        // R7: a read clears the flags; the byte before the clear is visible during the read
        tick(); rd = 1;
        peek();
        chk("R7 read shows old", status, 8'h55);
        tick(); rd = 0;
        peek();
        chk("R7 cleared", status, 8'h50);
        // R5: a ring fall leaves the ring flag clear
        ri = 0;
        tick(4);
        peek();
        chk("R5 fall no flag", status, 8'h10);
        // R3/R8: set the DSR flag, then read on the edge where the next DSR change lands
        dsr = 1;
        tick(4);
        peek();
        chk("R3 dsr rise", status, 8'h32);
        dsr = 0;
        tick(2); rd = 1;
        tick(); rd = 0;
        peek();
        chk("R8 coincident keep", status, 8'h12);
        tick(); rd = 1;
        tick(); rd = 0;
        peek();
        chk("R7 clear after", status, 8'h10);
        // R10: masked interrupt while flags still accumulate
        en = 0; dcd = 1;
        tick(4);
        peek();
        chk("R10 flag kept", status, 8'h98);
        chk("R10 irq masked", {7'd0, irq}, 8'h00);
        en = 1;
        tick();
        peek();
        chk("R10 irq on enable", {7'd0, irq}, 8'h01);
        // Random phase: scattered toggles, reads and enable changes
        for (int k = 0; k < 4000; k++) begin
            if ($urandom_range(0, 5) == 0) cts = ~cts;
            if ($urandom_range(0, 5) == 0) dsr = ~dsr;
            if ($urandom_range(0, 5) == 0) ri  = ~ri;
            if ($urandom_range(0, 5) == 0) dcd = ~dcd;
            rd = ($urandom_range(0, 3) == 0);
            en = ($urandom_range(0, 7) != 0);
            tick();
        end
        rd = 0;
        tick(2);
        finished = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule